// File: doc/BRIEF.md
# Striped Multi-Plane Cell Crossbar

This block switches fixed-size cells from a set of input ports to the same number of output ports. Internally it runs several identical crossbar planes side by side. Every cell entering a port is cut into equal-width slices, and each plane carries one slice. At the output the slices are put back together in their original bit positions. Adding planes widens the cell that crosses the fabric in one cycle, so the line rate goes up while the scheduler stays the same.

An external scheduler writes one configuration per cell time. The configuration gives each output a source-port index and an enable bit. The fabric keeps this configuration in a register and sends the same register value to every plane. Because of this, all slices of a cell always follow the same path. An output may name any input, so one input can feed several outputs in the same cycle.

Cells move one per cycle on a valid/ready interface at both edges. The fabric advances as one unit. A clock edge transfers cells only when every output register is either empty or being read (`out_ready` high). While the fabric is stalled, every `in_ready` bit is low and each output holds its cell. An input cell offered while `in_ready` is high is consumed at that edge. This is true even when no output selects it, in which case the cell is dropped. The cell width must be an exact multiple of the plane count.

Top module: `xbsf_fabric`

## Requirements
- R1: After reset, every `out_valid` bit is 0, every `out_cell` bit is 0, and all output enables in the stored configuration are 0. Until a configuration is loaded, cells produce no valid output.
- R2: When `cfg_load` is high at a clock edge, `cfg_sel` and `cfg_en` are stored at that edge. Cells accepted at that same edge still use the previous configuration, and cells from the next edge on use the new one. While `cfg_load` is low, changes on `cfg_sel` and `cfg_en` have no effect.
- R3: For output o with its enable set and select value s < N_PORTS, a valid cell on input s is delivered on output o bit-for-bit.
- R4: Slice j of a cell is bits [j*CELL_W/N_PLANES +: CELL_W/N_PLANES]. It travels through plane j and comes back out in the same bit position. All planes use one shared configuration, so every slice of a delivered cell comes from the same input.
- R5: Several outputs may select the same input in one cycle. Each of them then receives an identical copy of that input's cell.
- R6: An output whose enable bit is 0, or whose select value is N_PORTS or greater, shows `out_valid` = 0 and an all-zero `out_cell`.
- R7: An output that selects an input whose `in_valid` is low shows `out_valid` = 0 and an all-zero `out_cell`.
- R8: If any output holds a valid cell while its `out_ready` is low, every `in_ready` bit is low and all output registers keep their contents unchanged.
- R9: A cell held on an input during a stall is transferred at the first edge after every output can accept again.
- R10: A cell accepted at a clock edge appears on the outputs immediately after that edge, with exactly one register stage of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Store the configuration at this edge |
| cfg_sel | input | N_PORTS*SELW (18) | Source index per output; output o uses bits [o*SELW +: SELW] |
| cfg_en | input | N_PORTS (6) | Enable per output |
| in_valid | input | N_PORTS (6) | Cell present per input |
| in_ready | output | N_PORTS (6) | Fabric accepts input cells at this edge |
| in_cell | input | N_PORTS*CELL_W (192) | Input cells; input i uses bits [i*CELL_W +: CELL_W] |
| out_valid | output | N_PORTS (6) | Output cell present |
| out_ready | input | N_PORTS (6) | Downstream takes the output cell |
| out_cell | output | N_PORTS*CELL_W (192) | Reassembled output cells |

## Verification
Faults are visible at the ports within a few cycles. A plane that sees a different select than its neighbours would put one wrong byte lane into a delivered cell on the very next cycle. A configuration register that updates without `cfg_load`, or updates at the wrong edge, would route the cycle's cell from an unexpected source. A wrong stall decision would either overwrite a held output cell or fail to deliver the pending input cell on the first free edge. Each test gives every input and every slice its own byte value, so a single misrouted lane changes a compared cell.

// File: rtl/xbsf_pkg.sv
package xbsf_pkg;

  // Width of an index that can name n items (at least one bit).
  function automatic int idx_bits(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/xbsf_cfg_reg.sv
module xbsf_cfg_reg #(
  parameter int N    = 6,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [N*SELW-1:0] sel_in,
  input  logic [N-1:0]    en_in,
  output logic [N*SELW-1:0] sel_q,
  output logic [N-1:0]    en_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= '0;
    end else if (load) begin
      sel_q <= sel_in;
      en_q  <= en_in;
    end
  end

  // Stored configuration only moves on a load
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(sel_q) && $stable(en_q)));

endmodule

// File: rtl/xbsf_plane.sv
module xbsf_plane #(
  parameter int N    = 6,
  parameter int SW   = 8,
  parameter int SELW = 3
) (
  input  logic [N*SW-1:0]   in_data,
  input  logic [N-1:0]      in_valid,
  input  logic [N*SELW-1:0] sel,
  input  logic [N-1:0]      en,
  output logic [N*SW-1:0]   out_data,
  output logic [N-1:0]      out_hit
);

  // Each output picks at most one input; out-of-range selects match nothing
  always_comb begin
    out_hit  = '0;
    out_data = '0;
    for (int o = 0; o < N; o++) begin
      for (int i = 0; i < N; i++) begin
        if (en[o] && (sel[o*SELW +: SELW] == SELW'(i)) && in_valid[i]) begin
          out_hit[o]            = 1'b1;
          out_data[o*SW +: SW]  = in_data[i*SW +: SW];
        end
      end
    end
  end

endmodule

// File: rtl/xbsf_out_stage.sv
module xbsf_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         load_valid,
  input  logic [W-1:0] load_data,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= load_valid;
      out_data  <= load_valid ? load_data : '0;
    end
  end

  // A cell not taken downstream stays put
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // Empty outputs show zeros
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));

endmodule

// File: rtl/xbsf_fabric.sv
module xbsf_fabric #(
  parameter  int N_PORTS  = 6,
  parameter  int CELL_W   = 32,
  parameter  int N_PLANES = 4,
  localparam int SELW     = xbsf_pkg::idx_bits(N_PORTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_load,
  input  logic [N_PORTS*SELW-1:0]   cfg_sel,
  input  logic [N_PORTS-1:0]        cfg_en,
  input  logic [N_PORTS-1:0]        in_valid,
  output logic [N_PORTS-1:0]        in_ready,
  input  logic [N_PORTS*CELL_W-1:0] in_cell,
  output logic [N_PORTS-1:0]        out_valid,
  input  logic [N_PORTS-1:0]        out_ready,
  output logic [N_PORTS*CELL_W-1:0] out_cell
);

  localparam int SW = CELL_W / N_PLANES;

  logic [N_PORTS*SELW-1:0]   sel_q;
  logic [N_PORTS-1:0]        en_q;
  logic [N_PORTS*SW-1:0]     pl_in  [N_PLANES];
  logic [N_PORTS*SW-1:0]     pl_out [N_PLANES];
  logic [N_PORTS-1:0]        pl_hit [N_PLANES];
  logic [N_PORTS*CELL_W-1:0] cell_nx;
  logic                      adv;

  xbsf_cfg_reg #(.N(N_PORTS), .SELW(SELW)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cfg_load),
    .sel_in (cfg_sel),
    .en_in  (cfg_en),
    .sel_q  (sel_q),
    .en_q   (en_q)
  );

  // Cut each input cell into per-plane slices
  always_comb begin
    for (int p = 0; p < N_PLANES; p++) begin
      for (int i = 0; i < N_PORTS; i++) begin
        pl_in[p][i*SW +: SW] = in_cell[i*CELL_W + p*SW +: SW];
      end
    end
  end

  genvar gp;
  generate
    for (gp = 0; gp < N_PLANES; gp++) begin : g_plane
      xbsf_plane #(.N(N_PORTS), .SW(SW), .SELW(SELW)) u_plane (
        .in_data  (pl_in[gp]),
        .in_valid (in_valid),
        .sel      (sel_q),
        .en       (en_q),
        .out_data (pl_out[gp]),
        .out_hit  (pl_hit[gp])
      );
      if (gp > 0) begin : g_agree
        // All planes share one decision
        p_planes_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
          pl_hit[gp] == pl_hit[0]);
      end
    end
  endgenerate

  // Put slices back in their original bit positions
  always_comb begin
    for (int o = 0; o < N_PORTS; o++) begin
      for (int p = 0; p < N_PLANES; p++) begin
        cell_nx[o*CELL_W + p*SW +: SW] = pl_out[p][o*SW +: SW];
      end
    end
  end

  assign adv      = &(~out_valid | out_ready);
  assign in_ready = {N_PORTS{adv}};

  genvar go;
  generate
    for (go = 0; go < N_PORTS; go++) begin : g_out
      xbsf_out_stage #(.W(CELL_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (adv),
        .load_valid (pl_hit[0][go]),
        .load_data  (cell_nx[go*CELL_W +: CELL_W]),
        .out_ready  (out_ready[go]),
        .out_valid  (out_valid[go]),
        .out_data   (out_cell[go*CELL_W +: CELL_W])
      );
    end
  endgenerate

  // With nothing pending the fabric must accept
  p_ready_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == '0) |-> (in_ready == {N_PORTS{1'b1}}));

endmodule

// File: tb/sim_xbsf_fabric.sv
`timescale 1ns/1ps
module sim_xbsf_fabric;
  localparam int N = 6, W = 32, K = 4, SELW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cfg_load;
  logic [N*SELW-1:0] cfg_sel;
  logic [N-1:0] cfg_en, in_valid, in_ready, out_valid, out_ready;
  logic [N*W-1:0] in_cell, out_cell;

  xbsf_fabric #(.N_PORTS(N), .CELL_W(W), .N_PLANES(K)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_sel(cfg_sel),
    .cfg_en(cfg_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_cell(in_cell), .out_valid(out_valid), .out_ready(out_ready),
    .out_cell(out_cell));

  int n_chk = 0, n_fail = 0;
  logic [SELW-1:0] m_sel [N];
  logic            m_en  [N];

  task automatic chk(string req, logic [W:0] act, logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mk(int i, int seed);
    logic [W-1:0] c;
    for (int p = 0; p < K; p++) c[p*8 +: 8] = 8'(seed*29 + i*K + p + 1);
    return c;
  endfunction

  task automatic drive(logic [N-1:0] vmask, int seed);
    in_valid = vmask;
    for (int i = 0; i < N; i++) in_cell[i*W +: W] = mk(i, seed);
  endtask

  task automatic set_cfg(input int s[N], input logic [N-1:0] e);
    for (int o = 0; o < N; o++) cfg_sel[o*SELW +: SELW] = SELW'(s[o]);
    cfg_en = e;
    cfg_load = 1'b1;
  endtask

  // One cycle with outputs ready; check all outputs after the edge
  task automatic run_cycle(string req);
    logic [N-1:0] sv;
    logic [N*W-1:0] sc;
    logic [SELW-1:0] ss [N];
    logic se [N];
    logic ev;
    logic [W-1:0] ed;
    sv = in_valid; sc = in_cell;
    for (int o = 0; o < N; o++) begin ss[o] = m_sel[o]; se[o] = m_en[o]; end
    @(negedge clk);
    for (int o = 0; o < N; o++) begin
      ev = se[o] && (int'(ss[o]) < N) && sv[ss[o]];
      ed = ev ? sc[int'(ss[o])*W +: W] : '0;
      chk(req, {out_valid[o], out_cell[o*W +: W]}, {ev, ed});
    end
    if (cfg_load) begin
      for (int o = 0; o < N; o++) begin
        m_sel[o] = cfg_sel[o*SELW +: SELW]; m_en[o] = cfg_en[o];
      end
      cfg_load = 1'b0;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_load = 1'b0; cfg_sel = '0; cfg_en = '0;
    in_valid = '0; in_cell = '0; out_ready = '1;
    for (int o = 0; o < N; o++) begin m_sel[o] = '0; m_en[o] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 valid", {{(W+1-N){1'b0}}, out_valid}, '0);
    chk("R1 cell", {1'b0, out_cell[W-1:0]}, '0);
    chk("R1 ready", {{(W+1-N){1'b0}}, in_ready}, {{(W+1-N){1'b0}}, {N{1'b1}}});
    drive('1, 1);
    run_cycle("R1 no cfg");
  endtask

  task automatic t_perm();
    int s[N] = '{5, 4, 3, 2, 1, 0};
    set_cfg(s, '1);
    drive('1, 2);
    run_cycle("R2 old cfg at load edge");
    drive('1, 3);
    #1 chk("R10 before edge", {{(W+1-N){1'b0}}, out_valid}, '0);
    run_cycle("R3 R4 R10 permutation");
    drive('1, 4);
    run_cycle("R3 R4 second pattern");
  endtask

  task automatic t_noload();
    int s[N] = '{0, 0, 0, 0, 0, 0};
    set_cfg(s, '0);
    cfg_load = 1'b0;
    drive('1, 5);
    run_cycle("R2 no load ignored");
  endtask

  task automatic t_multicast();
    int s[N] = '{2, 2, 2, 2, 2, 2};
    set_cfg(s, '1);
    run_cycle("R2 load");
    drive('1, 6);
    run_cycle("R5 multicast");
  endtask

  task automatic t_unmatched();
    int s[N] = '{0, 6, 7, 1, 3, 4};
    set_cfg(s, 6'b111110);
    run_cycle("R2 load");
    drive('1, 7);
    run_cycle("R6 unmatched");
  endtask

  task automatic t_invalid();
    int s[N] = '{0, 1, 2, 3, 4, 5};
    set_cfg(s, '1);
    run_cycle("R2 load");
    drive(6'b101001, 8);
    run_cycle("R7 idle input");
  endtask

  task automatic t_stall();
    logic [N*W-1:0] held;
    drive('1, 10);
    run_cycle("R3 before stall");
    held = out_cell;
    out_ready = 6'b111110;
    drive('1, 11);
    #1 chk("R8 ready low", {{(W+1-N){1'b0}}, in_ready}, '0);
    @(negedge clk);
    for (int o = 0; o < N; o++)
      chk("R8 hold", {out_valid[o], out_cell[o*W +: W]}, {1'b1, held[o*W +: W]});
    out_ready = '1;
    #1 chk("R9 ready back", {{(W+1-N){1'b0}}, in_ready}, {{(W+1-N){1'b0}}, {N{1'b1}}});
    run_cycle("R9 pending cell");
  endtask

  initial begin
    t_reset();
    t_perm();
    t_noload();
    t_multicast();
    t_unmatched();
    t_invalid();
    t_stall();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule